// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block connects a synchronous single-cycle request port to an external asynchronous static RAM of 128K bytes. A requester pulses `req` for one clock with a direction flag, a 17-bit byte address and, for a store, a data byte. The block then runs the memory's control pins through a timed read or write phase. It returns a one-clock acknowledge, and for a load it also presents the byte it fetched.

Every phase length is a whole number of system clocks. Each one comes from the memory's speed grade (55 ns or 70 ns parts) and the system clock period. The required time is divided by the period, rounded up, and given a floor of one clock. Between accesses the memory is deselected so that it stays in its low-power standby state. After each load the block waits out the memory's output release time before it can drive the data bus again.

The data bus is split into an output byte, an output-enable and an input byte. The pad tri-state logic sits outside the block.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, and whenever `busy` is low, the memory is deselected: `sram_ce_n`=1, `sram_ce2`=0, `sram_we_n`=1, `sram_oe_n`=1 and `sram_dq_oe`=0.
- R2: An accepted load selects the memory (`sram_ce_n`=0 with `sram_ce2`=1) and holds `sram_oe_n`=0, `sram_we_n`=1 and a steady `sram_addr` for exactly RD clocks. RD is the larger of ceil(access time / period) and ceil(output-enable time / period). The access time is 55 or 70 ns and the output-enable time is 20 or 30 ns, by grade, so RD is 7 at 8 ns with the fast grade.
- R3: The byte on `sram_dq_i` at the last clock edge of the load phase appears on `rd_data` together with `ack`. It stays there until the next load completes.
- R4: An accepted store holds `sram_we_n`=0 with both enables active, `sram_oe_n`=1, and a steady address and `sram_dq_o` for exactly WR clocks. WR is the larger of ceil(pulse time / period) and ceil(25 ns / period), with a pulse time of 55 or 70 ns, so WR is 7 at 8 ns with the fast grade. `sram_dq_oe` is 1 only while `sram_we_n` is 0.
- R5: `ack` is high for exactly one clock per access. For a store this is the clock after `sram_we_n` returns high; for a load it is the clock after the last load clock. For a store, `busy` is already low in that clock.
- R6: After a load the memory stays deselected and `busy` stays high for GAP clocks. GAP is ceil(release time / period), with a release time of 25 or 30 ns, so GAP is 4 at 8 ns with the fast grade. `sram_dq_oe` never rises within GAP clocks of `sram_oe_n` returning high.
- R7: A `req` pulse that arrives while `busy` is high has no effect. No access starts, and the addressed memory byte keeps its old value.
- R8: A request given in the acknowledge clock of a store is accepted at once, so `sram_we_n` falls on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | One-clock request strobe |
| req_wr | input | 1 | 1 = store, 0 = load |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Byte to store |
| busy | output | 1 | Access or turnaround in progress |
| ack | output | 1 | One-clock completion pulse |
| rd_data | output | 8 | Last byte loaded |
| sram_ce_n | output | 1 | Active-low chip enable |
| sram_ce2 | output | 1 | Active-high chip enable |
| sram_we_n | output | 1 | Active-low write enable |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_addr | output | 17 | Memory address |
| sram_dq_o | output | 8 | Data driven toward memory |
| sram_dq_oe | output | 1 | Drive enable for `sram_dq_o` |
| sram_dq_i | input | 8 | Data returned by memory |

## Verification
A corrupted phase counter shows up on the pins within one clock. The select, output-enable or write-enable pulse becomes a cycle too long or too short, and the per-clock pin comparison against the reference flags it in that cycle. A short load also makes the modelled memory return inverted data, so `rd_data` is wrong at the acknowledge. A sequencer that skips the turnaround, or accepts requests while busy, drives the bus while the modelled memory is still releasing it, or starts an access the reference does not expect. Either fault shows in the cycle after the offending edge.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2,
    PH_GAP   = 2'd3
  } phase_e;

  // Whole clocks covering a time in ns, never fewer than one.
  function automatic int clocks_for(input int ns, input int clk_ps);
    int c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Grade-dependent memory timing in ns.
  function automatic int t_access(input int grade);
    return (grade >= 70) ? 70 : 55;
  endfunction

  function automatic int t_oe_valid(input int grade);
    return (grade >= 70) ? 30 : 20;
  endfunction

  function automatic int t_release(input int grade);
    return (grade >= 70) ? 30 : 25;
  endfunction

  function automatic int t_data_setup(input int grade);
    return (grade >= 0) ? 25 : 25;
  endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
  import asram_pkg::*;
#(
  parameter int RD_CYC  = 7,
  parameter int WR_CYC  = 7,
  parameter int GAP_CYC = 4,
  parameter int CNT_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             req_wr,
  input  logic             tmr_done,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             capture,
  output logic             busy,
  output logic             ack,
  output logic             ce_n,
  output logic             ce2,
  output logic             we_n,
  output logic             oe_n,
  output logic             dq_oe
);

  localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LAST  = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_CYC - 1);

  phase_e ph_q, ph_nxt;
  logic   wr_end, sel_nxt;

  assign accept  = (ph_q == PH_IDLE) && req;
  assign capture = (ph_q == PH_READ) && tmr_done;
  assign wr_end  = (ph_q == PH_WRITE) && tmr_done;

  always_comb begin
    ph_nxt = ph_q;
    unique case (ph_q)
      PH_IDLE:  if (req) ph_nxt = req_wr ? PH_WRITE : PH_READ;
      PH_READ:  if (tmr_done) ph_nxt = PH_GAP;
      PH_WRITE: if (tmr_done) ph_nxt = PH_IDLE;
      PH_GAP:   if (tmr_done) ph_nxt = PH_IDLE;
      default:  ph_nxt = PH_IDLE;
    endcase
  end

  assign tmr_load = accept || capture;
  assign tmr_val  = accept ? (req_wr ? WR_LAST : RD_LAST) : GAP_LAST;
  assign sel_nxt  = (ph_nxt == PH_READ) || (ph_nxt == PH_WRITE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_IDLE;
      busy  <= 1'b0;
      ack   <= 1'b0;
      ce_n  <= 1'b1;
      ce2   <= 1'b0;
      we_n  <= 1'b1;
      oe_n  <= 1'b1;
      dq_oe <= 1'b0;
    end else begin
      ph_q  <= ph_nxt;
      busy  <= (ph_nxt != PH_IDLE);
      ack   <= capture || wr_end;
      ce_n  <= !sel_nxt;
      ce2   <= sel_nxt;
      we_n  <= (ph_nxt != PH_WRITE);
      oe_n  <= (ph_nxt != PH_READ);
      dq_oe <= (ph_nxt == PH_WRITE);
    end
  end

endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_wdata,
  output logic [DATA_W-1:0] out_rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_addr  <= '0;
      out_wdata <= '0;
      out_rdata <= '0;
    end else begin
      if (accept) begin
        out_addr  <= in_addr;
        out_wdata <= in_wdata;
      end
      if (capture) begin
        out_rdata <= mem_rdata;
      end
    end
  end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int CLK_PS   = 8000,
  parameter int GRADE_NS = 55
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              ack,
  output logic [DATA_W-1:0] rd_data,
  output logic              sram_ce_n,
  output logic              sram_ce2,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_i
);

  localparam int RD_CYC  = imax(clocks_for(t_access(GRADE_NS), CLK_PS),
                                clocks_for(t_oe_valid(GRADE_NS), CLK_PS));
  localparam int WR_CYC  = imax(clocks_for(t_access(GRADE_NS), CLK_PS),
                                clocks_for(t_data_setup(GRADE_NS), CLK_PS));
  localparam int GAP_CYC = clocks_for(t_release(GRADE_NS), CLK_PS);
  localparam int MAX_CYC = imax(imax(RD_CYC, WR_CYC), GAP_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             tmr_load, tmr_done, accept, capture;
  logic [CNT_W-1:0] tmr_val;

  asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  asram_fsm #(
    .RD_CYC  (RD_CYC),
    .WR_CYC  (WR_CYC),
    .GAP_CYC (GAP_CYC),
    .CNT_W   (CNT_W)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .req_wr   (req_wr),
    .tmr_done (tmr_done),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .accept   (accept),
    .capture  (capture),
    .busy     (busy),
    .ack      (ack),
    .ce_n     (sram_ce_n),
    .ce2      (sram_ce2),
    .we_n     (sram_we_n),
    .oe_n     (sram_oe_n),
    .dq_oe    (sram_dq_oe)
  );

  asram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .capture   (capture),
    .in_addr   (req_addr),
    .in_wdata  (req_wdata),
    .mem_rdata (sram_dq_i),
    .out_addr  (sram_addr),
    .out_wdata (sram_dq_o),
    .out_rdata (rd_data)
  );

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 8,
  parameter int RD_CYC  = 7,
  parameter int WR_CYC  = 7,
  parameter int GAP_CYC = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              ack,
  input logic              sram_ce_n,
  input logic              sram_ce2,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic [ADDR_W-1:0] sram_addr,
  input logic [DATA_W-1:0] sram_dq_o,
  input logic              sram_dq_oe
);

  int rd_len, wr_len, since_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_len   <= 0;
      wr_len   <= 0;
      since_rd <= GAP_CYC + 1;
    end else begin
      rd_len   <= sram_oe_n ? 0 : rd_len + 1;
      wr_len   <= sram_we_n ? 0 : wr_len + 1;
      if (!sram_oe_n)               since_rd <= 0;
      else if (since_rd <= GAP_CYC) since_rd <= since_rd + 1;
    end
  end

  a_r1_idle_standby: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (sram_ce_n && !sram_ce2 && sram_we_n && sram_oe_n && !sram_dq_oe));

  a_r2_read_len: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_oe_n) |-> (rd_len == RD_CYC));

  a_r2_read_pins: assert property (@(posedge clk) disable iff (rst)
    !sram_oe_n |-> (sram_we_n && !sram_ce_n && sram_ce2));

  a_r2_addr_steady: assert property (@(posedge clk) disable iff (rst)
    (!sram_ce_n && !$past(sram_ce_n)) |-> $stable(sram_addr));

  a_r4_write_len: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_we_n) |-> (wr_len == WR_CYC));

  a_r4_drive_in_write: assert property (@(posedge clk) disable iff (rst)
    sram_dq_oe |-> (!sram_we_n && sram_oe_n && !sram_ce_n));

  a_r4_data_steady: assert property (@(posedge clk) disable iff (rst)
    (!sram_we_n && !$past(sram_we_n)) |-> $stable(sram_dq_o));

  a_r5_ack_single: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  a_r6_turnaround: assert property (@(posedge clk) disable iff (rst)
    sram_dq_oe |-> (since_rd > GAP_CYC));

endmodule

bind asram_ctrl asram_ctrl_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .RD_CYC  (RD_CYC),
  .WR_CYC  (WR_CYC),
  .GAP_CYC (GAP_CYC)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .ack        (ack),
  .sram_ce_n  (sram_ce_n),
  .sram_ce2   (sram_ce2),
  .sram_we_n  (sram_we_n),
  .sram_oe_n  (sram_oe_n),
  .sram_addr  (sram_addr),
  .sram_dq_o  (sram_dq_o),
  .sram_dq_oe (sram_dq_oe)
);

// File: tb/asram_ctrl_bench.sv
`timescale 1ns/1ps
module asram_ctrl_bench;

  localparam int CLK_NS = 8;
  localparam int ACC_NS = 55;
  localparam int REL_NS = 25;
  localparam int RD_E   = (ACC_NS + CLK_NS - 1) / CLK_NS;
  localparam int WR_E   = (ACC_NS + CLK_NS - 1) / CLK_NS;
  localparam int GAP_E  = (REL_NS + CLK_NS - 1) / CLK_NS;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0, req_wr = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        busy, ack, sram_ce_n, sram_ce2, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [7:0]  rd_data, sram_dq_o;
  logic [7:0]  sram_dq_i = 8'h00;
  logic [16:0] sram_addr;

  always #(CLK_NS/2) clk = ~clk;

  asram_ctrl u_asram_ctrl (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .ack(ack), .rd_data(rd_data),
    .sram_ce_n(sram_ce_n), .sram_ce2(sram_ce2), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_addr(sram_addr), .sram_dq_o(sram_dq_o),
    .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference: 0 idle, 1 load, 2 store, 3 turnaround
  int          m_ph = 0, m_left = 0;
  bit          m_ack = 0, m_ack_rd = 0;
  logic [16:0] m_addr = '0;
  logic [7:0]  m_wdata = '0, m_rdata = '0;
  logic [7:0]  ref_mem [int];
  logic [7:0]  dev_mem [int];
  int          drv_cnt = 0, rel_cnt = 100;

  function automatic logic [7:0] init_val(input int a);
    return 8'(a) ^ 8'h96;
  endfunction

  function automatic logic [7:0] ref_rd(input int a);
    return ref_mem.exists(a) ? ref_mem[a] : init_val(a);
  endfunction

  function automatic logic [7:0] dev_rd(input int a);
    return dev_mem.exists(a) ? dev_mem[a] : init_val(a);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  task automatic model_step();
    m_ack = 0;
    if (rst) begin
      m_ph = 0; m_left = 0; m_ack_rd = 0;
    end else begin
      case (m_ph)
        1: begin
          m_left--;
          if (m_left == 0) begin
            m_ack = 1; m_ack_rd = 1; m_rdata = ref_rd(int'(m_addr));
            m_ph = 3; m_left = GAP_E;
          end
        end
        2: begin
          m_left--;
          if (m_left == 0) begin m_ack = 1; m_ack_rd = 0; m_ph = 0; end
        end
        3: begin
          m_left--;
          if (m_left == 0) m_ph = 0;
        end
        default: if (req) begin
          m_addr = req_addr;
          if (req_wr) begin
            m_ph = 2; m_left = WR_E; m_wdata = req_wdata;
            ref_mem[int'(req_addr)] = req_wdata;
          end else begin
            m_ph = 1; m_left = RD_E;
          end
        end
      endcase
    end
  endtask

  // memory behaviour at the pins, updated between edges
  task automatic device_step();
    bit sel;
    sel = !sram_ce_n && sram_ce2;
    if (sel && !sram_we_n && sram_dq_oe) dev_mem[int'(sram_addr)] = sram_dq_o;
    if (sel && sram_we_n && !sram_oe_n) begin
      drv_cnt++; rel_cnt = 0;
    end else begin
      drv_cnt = 0;
      if (rel_cnt < 100) rel_cnt++;
    end
    sram_dq_i = (drv_cnt * CLK_NS >= ACC_NS) ? dev_rd(int'(sram_addr)) : ~dev_rd(int'(sram_addr));
  endtask

  task automatic compare();
    string tag;
    bit    s;
    logic [5:0] act, exp;
    tag = (m_ph == 0) ? "R1" : (m_ph == 1) ? "R2" : (m_ph == 2) ? "R4" : "R6";
    s = (m_ph == 1) || (m_ph == 2);
    act = {sram_ce_n, sram_ce2, sram_we_n, sram_oe_n, sram_dq_oe, busy};
    exp = {!s, s, m_ph != 2, m_ph != 1, m_ph == 2, m_ph != 0};
    chk(act === exp, {tag, " pins"}, 32'(act), 32'(exp));
    chk(ack === m_ack, "R5 ack", 32'(ack), 32'(m_ack));
    if (s) chk(sram_addr === m_addr, {tag, " addr"}, 32'(sram_addr), 32'(m_addr));
    if (m_ph == 2) chk(sram_dq_o === m_wdata, "R4 wdata", 32'(sram_dq_o), 32'(m_wdata));
    if (m_ack && m_ack_rd) chk(rd_data === m_rdata, "R3 rdata", 32'(rd_data), 32'(m_rdata));
    if (sram_dq_oe) chk(rel_cnt > GAP_E, "R6 bus release", 32'(rel_cnt), 32'(GAP_E + 1));
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
    device_step();
    compare();
  endtask

  task automatic wait_idle();
    while (m_ph != 0) tick();
  endtask

  task automatic access(input bit wr, input logic [16:0] a, input logic [7:0] d);
    wait_idle();
    req = 1; req_wr = wr; req_addr = a; req_wdata = d;
    tick();
    req = 0;
    while (!m_ack) tick();
  endtask

  initial begin
    #(200000 * CLK_NS);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) tick();
    rst = 0;
    for (int i = 0; i < 3; i++) tick();
    chk(rd_data === 8'h00 && !busy, "R1 reset state", 32'({busy, rd_data}), 32'h0);

    access(1, 17'h00001, 8'h3C);
    // R8: next store offered in the acknowledge clock
    req = 1; req_wr = 1; req_addr = 17'h1FFFF; req_wdata = 8'hC3;
    tick();
    req = 0;
    chk(sram_we_n === 1'b0, "R8 back-to-back store", 32'(sram_we_n), 32'h0);
    while (!m_ack) tick();

    access(0, 17'h00001, 8'h00);
    chk(rd_data === 8'h3C, "R3 load 1", 32'(rd_data), 32'h3C);
    access(0, 17'h1FFFF, 8'h00);
    chk(rd_data === 8'hC3, "R3 load top", 32'(rd_data), 32'hC3);

    // R7: store offered mid-load and again mid-turnaround must be dropped
    wait_idle();
    req = 1; req_wr = 0; req_addr = 17'h00005;
    tick();
    req = 0;
    tick(); tick();
    req = 1; req_wr = 1; req_addr = 17'h00005; req_wdata = 8'hFF;
    tick();
    req = 0;
    while (m_ph != 3) tick();
    req = 1; req_wr = 1; req_addr = 17'h00005; req_wdata = 8'hEE;
    tick();
    req = 0;
    // store right after the turnaround (R6 spacing)
    access(1, 17'h00100, 8'h5A);
    access(0, 17'h00005, 8'h00);
    chk(rd_data === init_val(5), "R7 ignored store", 32'(rd_data), 32'(init_val(5)));
    chk(rd_data === init_val(5), "R3 hold check prep", 32'(rd_data), 32'(init_val(5)));
    tick(); tick();
    chk(rd_data === init_val(5), "R3 rdata holds", 32'(rd_data), 32'(init_val(5)));

    for (int i = 0; i < 8; i++) access(1, 17'(i * 4099 + 3), 8'(i * 37 + 1));
    for (int i = 7; i >= 0; i--) begin
      access(0, 17'(i * 4099 + 3), 8'h00);
      chk(rd_data === 8'(i * 37 + 1), "R3 pattern load", 32'(rd_data), 32'(i * 37 + 1));
    end
    for (int i = 0; i < 6; i++) tick();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule